// File: doc/BRIEF.md
# Codec Channel Command Controller

This block interprets single-byte control commands for a group of four voice codec channels and tracks the operating state of each channel. Command bytes arrive on a byte-plus-valid strobe. Configuration values arrive through a separate register-write strobe that carries an address and data. The configuration covers a channel-selection mask, per-channel time-slot and highway fields, and one group-wide signalling-mode flag. The standby, activate and software-reset commands act only on the channels selected in the mask. The full group reset ignores the mask.

For each channel the block drives a PCM input enable and a PCM output enable; a low output enable means the output is tri-stated. It also drives a data-valid qualifier. After a channel is activated, data-valid stays low until two frame-sync pulses have been seen on the `fsync` input. This gives the downstream datapath a settled frame before any samples are used.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: After `rst`, every channel is in standby with status 0, data-valid 0 and both PCM enables 0. The mask is all ones, signalling mode is 0, the slot of channel i equals i, and every highway bit is 0.
- R2: Command byte 8'h00 puts each mask-selected channel in standby: status 0, PCM input enable 0, data-valid 0. Programmed fields are kept.
- R3: Command byte 8'h0E makes each mask-selected channel active: status 1, PCM input enable 1, PCM output enable 1. Unselected channels are not changed.
- R4: An active channel raises data-valid only on the second `fsync` pulse after its most recent activate command, and it keeps data-valid high afterwards. A repeated activate clears the count.
- R5: Command byte 8'h02 puts only the mask-selected channels in standby. The mask, slots, highway bits and signalling mode are unchanged.
- R6: Command byte 8'h04 restores the full R1 state for all four channels and all group fields, whatever the mask holds.
- R7: Command byte 8'h06, and any byte other than 8'h00, 8'h02, 8'h04 and 8'h0E, changes no state.
- R8: Register writes use this map. Address 0 loads the mask from data bits [3:0]. Address 1 loads signalling mode from data bit 0. Address 4+i loads channel i's slot from data bits [6:0] and its highway bit from bit 7. Addresses 2 and 3 are ignored.
- R9: A channel in standby drives its PCM output enable equal to the signalling-mode bit. Otherwise its output is tri-stated.
- R10: A command byte has no effect while `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command opcode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_data | input | 8 | Register write data |
| fsync | input | 1 | Frame-sync pulse |
| chan_status | output | 4 | Per-channel active flag |
| pcm_in_en | output | 4 | Per-channel PCM input enable |
| pcm_out_en | output | 4 | Per-channel PCM output enable (0 = tri-state) |
| data_valid | output | 4 | Per-channel PCM data qualifier |
| mask_q | output | 4 | Current channel-selection mask |
| sig_mode_q | output | 1 | Group signalling-mode flag |
| slot_q | output | 28 | Time slots, channel i at bits [7i+6:7i] |
| hwy_q | output | 4 | Per-channel highway bit |

## Verification
The hardest state to reach is a mix of channels at different points of the frame-sync count. The goal is a case where some channels are already valid and others have just been reactivated, so their counts must start over while their neighbours keep counting. The stimulus narrows the mask, reactivates a subset between `fsync` pulses, then widens the mask and reactivates every channel. The data-valid pattern must then step through each mix of states. Software reset under a partial mask is followed by read-back of slots and highway bits, which shows that only the channel state moved.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;
  localparam logic [7:0] OP_STANDBY  = 8'h00;
  localparam logic [7:0] OP_SWRST    = 8'h02;
  localparam logic [7:0] OP_HWRST    = 8'h04;
  localparam logic [7:0] OP_NOP      = 8'h06;
  localparam logic [7:0] OP_ACTIVATE = 8'h0E;

  typedef struct packed {
    logic standby;
    logic activate;
    logic sw_rst;
    logic hw_rst;
  } cmd_strobe_t;
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_cmd_pkg::*;
(
  input  logic        valid,
  input  logic [7:0]  op,
  output cmd_strobe_t stb
);
  always_comb begin
    stb = '0;
    if (valid) begin
      unique case (op)
        OP_STANDBY:  stb.standby  = 1'b1;
        OP_ACTIVATE: stb.activate = 1'b1;
        OP_SWRST:    stb.sw_rst   = 1'b1;
        OP_HWRST:    stb.hw_rst   = 1'b1;
        default:     stb = '0;  // NOP and unknown codes
      endcase
    end
  end
endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs #(
  parameter int NCH       = 4,
  parameter int SLOT_W    = 7,
  parameter int ADDR_W    = 3,
  parameter int SLOT_BASE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hw_rst,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            data,
  output logic [NCH-1:0]        mask,
  output logic                  sig_mode,
  output logic [NCH*SLOT_W-1:0] slots,
  output logic [NCH-1:0]        hwy
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SIG  = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst || hw_rst) begin
      mask     <= '1;
      sig_mode <= 1'b0;
    end else if (wr) begin
      if (addr == A_MASK) mask <= data[NCH-1:0];
      if (addr == A_SIG)  sig_mode <= data[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(SLOT_BASE + i);
    always_ff @(posedge clk) begin
      if (rst || hw_rst) begin
        slots[i*SLOT_W +: SLOT_W] <= SLOT_W'(i);
        hwy[i]                    <= 1'b0;
      end else if (wr && addr == A_SLOT) begin
        slots[i*SLOT_W +: SLOT_W] <= data[SLOT_W-1:0];
        hwy[i]                    <= data[7];
      end
    end
  end
endmodule

// File: rtl/chan_state.sv
module chan_state
  import chan_cmd_pkg::*;
#(
  parameter int FS_NEED = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  cmd_strobe_t stb,
  input  logic        fsync,
  input  logic        sig_mode,
  output logic        active,
  output logic        in_en,
  output logic        out_en,
  output logic        valid
);
  localparam int CW = $clog2(FS_NEED + 1);
  localparam logic [CW-1:0] CMAX = CW'(FS_NEED);

  logic [CW-1:0] fs_cnt;

  always_ff @(posedge clk) begin
    if (rst || stb.hw_rst) begin
      active <= 1'b0;
      fs_cnt <= '0;
    end else if (sel && (stb.standby || stb.sw_rst)) begin
      active <= 1'b0;
      fs_cnt <= '0;
    end else if (sel && stb.activate) begin
      active <= 1'b1;
      fs_cnt <= '0;
    end else if (active && fsync && fs_cnt != CMAX) begin
      fs_cnt <= fs_cnt + 1'b1;
    end
  end

  assign in_en  = active;
  assign out_en = active | sig_mode;
  assign valid  = active && (fs_cnt == CMAX);
endmodule

// File: rtl/chan_cmd_ctrl.sv
module chan_cmd_ctrl
  import chan_cmd_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int SLOT_W  = 7,
  parameter int ADDR_W  = 3,
  parameter int FS_NEED = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_byte,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_data,
  input  logic                  fsync,
  output logic [NCH-1:0]        chan_status,
  output logic [NCH-1:0]        pcm_in_en,
  output logic [NCH-1:0]        pcm_out_en,
  output logic [NCH-1:0]        data_valid,
  output logic [NCH-1:0]        mask_q,
  output logic                  sig_mode_q,
  output logic [NCH*SLOT_W-1:0] slot_q,
  output logic [NCH-1:0]        hwy_q
);
  cmd_strobe_t stb;

  chan_cmd_decode u_dec (
    .valid (cmd_valid),
    .op    (cmd_byte),
    .stb   (stb)
  );

  chan_cfg_regs #(.NCH(NCH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .hw_rst   (stb.hw_rst),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .data     (reg_data),
    .mask     (mask_q),
    .sig_mode (sig_mode_q),
    .slots    (slot_q),
    .hwy      (hwy_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_state #(.FS_NEED(FS_NEED)) u_st (
      .clk      (clk),
      .rst      (rst),
      .sel      (mask_q[i]),
      .stb      (stb),
      .fsync    (fsync),
      .sig_mode (sig_mode_q),
      .active   (chan_status[i]),
      .in_en    (pcm_in_en[i]),
      .out_en   (pcm_out_en[i]),
      .valid    (data_valid[i])
    );
  end
endmodule

// File: rtl/chan_cmd_ctrl_chk.sv
module chan_cmd_ctrl_chk #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_valid,
  input logic [7:0]            cmd_byte,
  input logic                  reg_wr,
  input logic                  fsync,
  input logic [NCH-1:0]        chan_status,
  input logic [NCH-1:0]        data_valid,
  input logic [NCH-1:0]        mask_q,
  input logic                  sig_mode_q,
  input logic [NCH*SLOT_W-1:0] slot_q
);
  a_r2_standby_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == 8'h00) |=> ((chan_status & $past(mask_q)) == '0));

  a_r3_activate_sets: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == 8'h0E) |=> ((chan_status & $past(mask_q)) == $past(mask_q)));

  a_r4_valid_after_fsync: assert property (@(posedge clk) disable iff (rst)
    ((data_valid & ~$past(data_valid)) != '0) |-> $past(fsync));

  a_r6_group_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == 8'h04) |=> (chan_status == '0 && mask_q == '1 && !sig_mode_q));

  a_r7_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == 8'h06 && !reg_wr) |=> ($stable(chan_status) && $stable(slot_q) && $stable(mask_q)));
endmodule

bind chan_cmd_ctrl chan_cmd_ctrl_chk #(.NCH(NCH), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_byte    (cmd_byte),
  .reg_wr      (reg_wr),
  .fsync       (fsync),
  .chan_status (chan_status),
  .data_valid  (data_valid),
  .mask_q      (mask_q),
  .sig_mode_q  (sig_mode_q),
  .slot_q      (slot_q)
);

// File: tb/sim_chan_cmd_ctrl.sv
module sim_chan_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_data = 8'h00;
  logic        fsync = 1'b0;
  logic [3:0]  chan_status, pcm_in_en, pcm_out_en, data_valid, mask_q, hwy_q;
  logic        sig_mode_q;
  logic [27:0] slot_q;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  chan_cmd_ctrl u0 (.*);

  // row: kind[1:0] (0 cmd, 1 reg write, 2 fsync), data[7:0], addr[2:0],
  //      expected status[3:0], data_valid[3:0], pcm_out_en[3:0]
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 8'h0E, 3'd0, 4'hF, 4'h0, 4'hF}, // R3 activate all
    {2'd2, 8'h00, 3'd0, 4'hF, 4'h0, 4'hF}, // R4 first fsync
    {2'd2, 8'h00, 3'd0, 4'hF, 4'hF, 4'hF}, // R4 second fsync
    {2'd2, 8'h00, 3'd0, 4'hF, 4'hF, 4'hF}, // R4 stays valid
    {2'd1, 8'h03, 3'd0, 4'hF, 4'hF, 4'hF}, // R8 mask=0011
    {2'd0, 8'h00, 3'd0, 4'hC, 4'hC, 4'hC}, // R2 standby ch0,1
    {2'd1, 8'h01, 3'd1, 4'hC, 4'hC, 4'hF}, // R9 sig mode on
    {2'd0, 8'h0E, 3'd0, 4'hF, 4'hC, 4'hF}, // R3 reactivate ch0,1
    {2'd2, 8'h00, 3'd0, 4'hF, 4'hC, 4'hF}, // R4
    {2'd2, 8'h00, 3'd0, 4'hF, 4'hF, 4'hF}, // R4
    {2'd0, 8'h06, 3'd0, 4'hF, 4'hF, 4'hF}, // R7 nop
    {2'd0, 8'h5A, 3'd0, 4'hF, 4'hF, 4'hF}, // R7 unknown
    {2'd1, 8'h0C, 3'd0, 4'hF, 4'hF, 4'hF}, // R8 mask=1100
    {2'd0, 8'h02, 3'd0, 4'h3, 4'h3, 4'hF}, // R5 soft reset ch2,3, R9
    {2'd1, 8'h00, 3'd1, 4'h3, 4'h3, 4'h3}, // R9 sig mode off
    {2'd0, 8'h0E, 3'd0, 4'hF, 4'h3, 4'hF}, // R3 activate ch2,3
    {2'd1, 8'h0F, 3'd0, 4'hF, 4'h3, 4'hF}, // R8 mask=1111
    {2'd0, 8'h0E, 3'd0, 4'hF, 4'h0, 4'hF}, // R4 re-activate clears count
    {2'd2, 8'h00, 3'd0, 4'hF, 4'h0, 4'hF}, // R4
    {2'd2, 8'h00, 3'd0, 4'hF, 4'hF, 4'hF}, // R4
    {2'd1, 8'hFF, 3'd2, 4'hF, 4'hF, 4'hF}  // R8 unused address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [7:0] d, input logic [2:0] a);
    @(negedge clk);
    cmd_valid = (kind == 2'd0);
    cmd_byte  = d;
    reg_wr    = (kind == 2'd1);
    reg_addr  = a;
    reg_data  = d;
    fsync     = (kind == 2'd2);
    @(negedge clk);
    cmd_valid = 1'b0;
    reg_wr    = 1'b0;
    fsync     = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(chan_status), 32'h0);
    chk("R1 outen", 32'(pcm_out_en), 32'h0);
    chk("R1 inen/valid", 32'({pcm_in_en, data_valid}), 32'h0);
    chk("R1 mask/sig", 32'({mask_q, sig_mode_q}), 32'h1E);
    chk("R1 slots", 32'(slot_q), 32'({7'd3, 7'd2, 7'd1, 7'd0}));
    chk("R1 hwy", 32'(hwy_q), 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24:23], VEC[i][22:15], VEC[i][14:12]);
      chk($sformatf("row %0d R2 R3 R4 R5 R7 R9 status", i), 32'(chan_status), 32'(VEC[i][11:8]));
      chk($sformatf("row %0d R3 inen", i), 32'(pcm_in_en), 32'(VEC[i][11:8]));
      chk($sformatf("row %0d R4 valid", i), 32'(data_valid), 32'(VEC[i][7:4]));
      chk($sformatf("row %0d R9 outen", i), 32'(pcm_out_en), 32'(VEC[i][3:0]));
    end
    chk("R8 unused addr keeps mask/sig", 32'({mask_q, sig_mode_q}), 32'h1E);

    // R8 slot write to channel 1
    step(2'd1, 8'h95, 3'd5);
    chk("R8 slot1", 32'(slot_q), 32'({7'd3, 7'd2, 7'h15, 7'd0}));
    chk("R8 hwy1", 32'(hwy_q), 32'h2);

    // R5 soft reset with mask 0010, sig mode 1
    step(2'd1, 8'h02, 3'd0);
    step(2'd1, 8'h01, 3'd1);
    step(2'd0, 8'h02, 3'd0);
    chk("R5 status", 32'(chan_status), 32'hD);
    chk("R5 slots kept", 32'(slot_q), 32'({7'd3, 7'd2, 7'h15, 7'd0}));
    chk("R5 hwy kept", 32'(hwy_q), 32'h2);
    chk("R5 mask/sig kept", 32'({mask_q, sig_mode_q}), 32'h5);

    // R10 command without strobe
    @(negedge clk);
    cmd_byte = 8'h0E;
    @(negedge clk);
    chk("R10 no strobe", 32'(chan_status), 32'hD);

    // R6 group reset ignores mask
    step(2'd0, 8'h04, 3'd0);
    chk("R6 status", 32'(chan_status), 32'h0);
    chk("R6 outen/valid", 32'({pcm_out_en, data_valid}), 32'h0);
    chk("R6 mask/sig", 32'({mask_q, sig_mode_q}), 32'h1E);
    chk("R6 slots", 32'(slot_q), 32'({7'd3, 7'd2, 7'd1, 7'd0}));
    chk("R6 hwy", 32'(hwy_q), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule